// File: doc/BRIEF.md
# I2C Transmit Queue Burst Writer

This block sits between the register front end of an I2C controller and its byte shifter. While queue mode is on, every byte that software writes to the data port goes into a 64-entry queue. The block hands the queued bytes to the shifter one at a time, in arrival order. After each byte it waits for the shifter to report whether the target acknowledged. An acknowledged byte lets the next one go. A not-acknowledged byte halts the burst at that byte.

Software reacts to two events, each with its own status bit and enable bit: the queue draining completely, and a target refusing a byte. After a refusal, the bytes still queued are discarded with one control write. Issuing a new bus command also releases the halt, and the remaining bytes then continue. Generating START and STOP conditions, formatting addresses and receiving data are handled elsewhere in the controller.

Two streams use valid/ready handshakes.
- **Push port.** A byte is taken on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` is low while queue mode is off or the queue is full. A byte offered while `push_ready` is low is dropped; the sender is not expected to hold it.
- **Shifter port.** The shifter may hold `tx_ready` low for as long as it likes. `tx_valid` and `tx_data` stay steady until the byte is taken, unless a flush withdraws them.

Top module: `i2c_txburst`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_level`=0), queue mode is off, `status`=0, `ack_err`=0, `irq`=0 and `tx_valid`=0.
- R2: On a control write (`ctl_we`), bit 6 of `ctl_wdata` becomes the queue-mode setting. Bit 7 empties the queue on that edge. Writing 0xC0 leaves the queue empty with queue mode on.
- R3: `push_ready` is 1 exactly when queue mode is on and the queue is not full. An accepted push raises `fifo_level` by one. With queue mode off, a push leaves the level unchanged.
- R4: The queue holds 64 bytes. A push while the queue is full is dropped: the level stays at 64 and the stored bytes later leave unchanged and in order.
- R5: Bytes are offered on `tx_valid`/`tx_data` in push order. Only one byte is outstanding at a time: no new byte is offered until `res_valid` reports on the previous one.
- R6: A result with `res_nak`=1 sets `status` bit 0 and `ack_err`. It then stops `tx_valid` until a flush or a `cmd_new` pulse.
- R7: A flush after a refusal discards the queued remainder. The level becomes 0 and none of those bytes are offered.
- R8: `status` bit 1 sets when an acknowledged result arrives and the queue is empty.
- R9: `irq` is high while any `status` bit has its matching `irq_en` bit set (bit 1 = drained, bit 0 = refusal). A `sts_clr_we` write clears each `status` bit whose bit is 1 in `sts_clr`.
- R10: A `cmd_new` pulse clears `ack_err` and releases the halt, so bytes still queued resume in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data (bit 7 flush, bit 6 queue mode) |
| push_valid | input | 1 | Data byte offered |
| push_data | input | 8 | Data byte |
| push_ready | output | 1 | Queue can take a byte |
| irq_en | input | 2 | Interrupt enables (bit 1 drained, bit 0 refusal) |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 2 | Write-one-to-clear mask for status |
| cmd_new | input | 1 | New bus command issued; releases halt |
| tx_valid | output | 1 | Byte offered to shifter |
| tx_data | output | 8 | Byte to shift |
| tx_ready | input | 1 | Shifter takes the byte |
| res_valid | input | 1 | Shifter reports byte result |
| res_nak | input | 1 | Result was a refusal |
| fifo_empty | output | 1 | Queue empty flag |
| fifo_level | output | 7 | Bytes queued |
| status | output | 2 | Event status (bit 1 drained, bit 0 refusal) |
| ack_err | output | 1 | Last byte refused (command-register view) |
| irq | output | 1 | Interrupt request |

## Verification
A read or write pointer that slips shows at once in the byte order on `tx_data`. Filling all 64 entries and draining them catches any wrap error within one pass. A sequencer stuck in the wrong state shows as a second offer before a result, or as bytes offered after a refusal; either appears within a cycle of the `res_valid` concerned. A status register that fails to set or clear shows on `irq` in the cycle after the event.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int CTL_FLUSH_BIT = 7;
  localparam int CTL_MODE_BIT  = 6;
  localparam int STS_NAK_BIT   = 0;
  localparam int STS_DRAIN_BIT = 1;
  localparam int STS_W         = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_HALT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/txb_seq.sv
module txb_seq
  import txb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic flush,
  input  logic cmd_new,
  input  logic fifo_empty,
  output logic tx_valid,
  input  logic tx_ready,
  input  logic res_valid,
  input  logic res_nak,
  output logic pop,
  output logic done_ack,
  output logic done_nak,
  output logic ack_err
);
  seq_state_t st;

  assign tx_valid = (st == SQ_IDLE) && mode_en && !fifo_empty && !flush;
  assign pop      = tx_valid && tx_ready;
  assign done_ack = (st == SQ_WAIT) && res_valid && !res_nak;
  assign done_nak = (st == SQ_WAIT) && res_valid && res_nak;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SQ_IDLE;
    end else begin
      case (st)
        SQ_IDLE: if (pop) st <= SQ_WAIT;
        SQ_WAIT: begin
          if (done_ack)      st <= SQ_IDLE;
          else if (done_nak) st <= SQ_HALT;
        end
        SQ_HALT: if (flush || cmd_new) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ack_err <= 1'b0;
    else if (done_nak) ack_err <= 1'b1;
    else if (cmd_new)  ack_err <= 1'b0;
  end
endmodule

// File: rtl/txb_irq.sv
module txb_irq
  import txb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_drain,
  input  logic             ev_nak,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  input  logic [STS_W-1:0] en,
  output logic [STS_W-1:0] status,
  output logic             irq
);
  logic [STS_W-1:0] set_v;

  always_comb begin
    set_v = '0;
    set_v[STS_DRAIN_BIT] = ev_drain;
    set_v[STS_NAK_BIT]   = ev_nak;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~(clr_we ? clr_mask : '0)) | set_v;
  end

  assign irq = |(status & en);
endmodule

// File: rtl/i2c_txburst.sv
module i2c_txburst
  import txb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic [1:0]    irq_en,
  input  logic          sts_clr_we,
  input  logic [1:0]    sts_clr,
  input  logic          cmd_new,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          res_valid,
  input  logic          res_nak,
  output logic          fifo_empty,
  output logic [LW-1:0] fifo_level,
  output logic [1:0]    status,
  output logic          ack_err,
  output logic          irq
);
  logic mode_en, flush, full, pop, done_ack, done_nak;

  assign flush = ctl_we && ctl_wdata[CTL_FLUSH_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_en <= 1'b0;
    else if (ctl_we) mode_en <= ctl_wdata[CTL_MODE_BIT];
  end

  assign push_ready = mode_en && !full;

  txb_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (push_valid && push_ready),
    .wr_data (push_data),
    .rd_en   (pop),
    .rd_data (tx_data),
    .level   (fifo_level),
    .full    (full),
    .empty   (fifo_empty)
  );

  txb_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_en    (mode_en),
    .flush      (flush),
    .cmd_new    (cmd_new),
    .fifo_empty (fifo_empty),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .res_valid  (res_valid),
    .res_nak    (res_nak),
    .pop        (pop),
    .done_ack   (done_ack),
    .done_nak   (done_nak),
    .ack_err    (ack_err)
  );

  txb_irq irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_drain (done_ack && fifo_empty),
    .ev_nak   (done_nak),
    .clr_we   (sts_clr_we),
    .clr_mask (sts_clr),
    .en       (irq_en),
    .status   (status),
    .irq      (irq)
  );
endmodule

// File: rtl/txb_chk.sv
module txb_chk #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic          push_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          res_valid,
  input logic          res_nak,
  input logic          fifo_empty,
  input logic [LW-1:0] fifo_level,
  input logic [1:0]    status,
  input logic [1:0]    irq_en,
  input logic          ack_err,
  input logic          irq
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n)                   pend <= 1'b0;
    else if (tx_valid && tx_ready) pend <= 1'b1;
    else if (res_valid)           pend <= 1'b0;
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));                                             // R4
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LW'(DEPTH)) |-> !push_ready);                            // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7]) |=> (fifo_empty && fifo_level == '0));         // R2
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !tx_valid);                                                    // R5
  AST_NAK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && res_valid && res_nak) |=> (!tx_valid && status[0] && ack_err)); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & irq_en) == 2'b00) |-> !irq);                                 // R9
endmodule

bind i2c_txburst txb_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .push_ready (push_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .res_valid  (res_valid),
  .res_nak    (res_nak),
  .fifo_empty (fifo_empty),
  .fifo_level (fifo_level),
  .status     (status),
  .irq_en     (irq_en),
  .ack_err    (ack_err),
  .irq        (irq)
);

// File: tb/i2c_txburst_tb.sv
module i2c_txburst_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       push_ready;
  logic [1:0] irq_en = '0;
  logic       sts_clr_we = 1'b0;
  logic [1:0] sts_clr = '0;
  logic       cmd_new = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_nak = 1'b0;
  logic       fifo_empty;
  logic [6:0] fifo_level;
  logic [1:0] status;
  logic       ack_err;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit eng_on = 1'b0;
  int nak_at = -1;
  int sent_cnt = 0;
  logic [7:0] sent [0:127];
  bit in_flight = 1'b0;
  int overlap = 0;

  always #2.5 clk = ~clk;

  i2c_txburst dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // shifter model
  initial begin
    forever begin
      @(negedge clk);
      if (eng_on && tx_valid) begin
        sent[sent_cnt] = tx_data;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        in_flight = 1'b1;
        sent_cnt++;
        repeat (2) @(negedge clk);
        res_nak = (sent_cnt - 1 == nak_at);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        res_nak = 1'b0;
        in_flight = 1'b0;
      end
    end
  end

  // watch for a second offer while one is outstanding (R5)
  initial begin
    forever begin
      @(negedge clk);
      if (in_flight && tx_valid && !res_valid) overlap++;
    end
  end

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); push_valid = 1'b1; push_data = v;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic clr_status(input logic [1:0] m);
    @(negedge clk); sts_clr_we = 1'b1; sts_clr = m;
    @(negedge clk); sts_clr_we = 1'b0; sts_clr = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    chk(fifo_level == 0, "R1 level", fifo_level, 0);
    chk(status == 2'b00 && irq == 1'b0, "R1 status/irq", {status, irq}, 0);
    chk(ack_err == 1'b0 && tx_valid == 1'b0, "R1 ack_err/tx_valid", {ack_err, tx_valid}, 0);
    chk(push_ready == 1'b0, "R1 mode off", push_ready, 0);
  endtask

  task automatic t_disabled_push;
    push(8'h11);
    chk(fifo_level == 0, "R3 push ignored when mode off", fifo_level, 0);
  endtask

  task automatic t_enable;
    ctl_write(8'hC0);
    chk(fifo_empty && push_ready, "R2 flush+enable", {fifo_empty, push_ready}, 3);
  endtask

  task automatic t_burst;
    eng_on = 1'b0; sent_cnt = 0; nak_at = -1;
    irq_en = 2'b10;
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk(fifo_level == 3, "R3 level after pushes", fifo_level, 3);
    chk(status[1] == 1'b0, "R8 not drained yet", status[1], 0);
    eng_on = 1'b1;
    settle(40);
    chk(sent_cnt == 3, "R5 count sent", sent_cnt, 3);
    chk(sent[0] == 8'hA1 && sent[1] == 8'hB2 && sent[2] == 8'hC3, "R5 order",
        sent[1], 8'hB2);
    chk(overlap == 0, "R5 single outstanding", overlap, 0);
    chk(status == 2'b10, "R8 drained status", status, 2);
    chk(irq == 1'b1, "R9 irq on drained", irq, 1);
    irq_en = 2'b01;
    settle(1);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    clr_status(2'b10);
    chk(status == 2'b00, "R9 w1c clear", status, 0);
  endtask

  task automatic t_full;
    eng_on = 1'b0; sent_cnt = 0; nak_at = -1;
    for (int i = 0; i < 64; i++) push(8'(i + 3));
    chk(fifo_level == 64, "R4 full level", fifo_level, 64);
    chk(push_ready == 1'b0, "R3 not ready when full", push_ready, 0);
    push(8'hEE);
    chk(fifo_level == 64, "R4 drop on full", fifo_level, 64);
    eng_on = 1'b1;
    settle(64 * 6 + 20);
    chk(sent_cnt == 64, "R4 drained count", sent_cnt, 64);
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) if (sent[i] != 8'(i + 3)) bad++;
      chk(bad == 0, "R4 contents intact", bad, 0);
    end
    clr_status(2'b11);
  endtask

  task automatic t_nak_flush;
    eng_on = 1'b0; sent_cnt = 0; nak_at = 1;
    irq_en = 2'b01;
    push(8'h21); push(8'h22); push(8'h23); push(8'h24);
    eng_on = 1'b1;
    settle(30);
    chk(sent_cnt == 2, "R6 stops at refused byte", sent_cnt, 2);
    chk(status[0] == 1'b1 && ack_err == 1'b1, "R6 nak flags", {status[0], ack_err}, 3);
    chk(tx_valid == 1'b0, "R6 no offer while halted", tx_valid, 0);
    chk(irq == 1'b1, "R9 irq on nak", irq, 1);
    chk(fifo_level == 2, "R6 remainder kept", fifo_level, 2);
    ctl_write(8'hC0);
    settle(20);
    chk(fifo_level == 0, "R7 flush discards", fifo_level, 0);
    chk(sent_cnt == 2, "R7 nothing sent after flush", sent_cnt, 2);
    clr_status(2'b01);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);
  endtask

  task automatic t_cmd_new;
    eng_on = 1'b0; sent_cnt = 0; nak_at = 0;
    push(8'h31); push(8'h32); push(8'h33);
    eng_on = 1'b1;
    settle(20);
    chk(sent_cnt == 1 && ack_err == 1'b1, "R6 halt before cmd_new", sent_cnt, 1);
    nak_at = -1;
    @(negedge clk); cmd_new = 1'b1;
    @(negedge clk); cmd_new = 1'b0;
    chk(ack_err == 1'b0, "R10 ack_err cleared", ack_err, 0);
    settle(30);
    chk(sent_cnt == 3 && sent[1] == 8'h32 && sent[2] == 8'h33, "R10 resume order",
        sent_cnt, 3);
  endtask

  initial begin
    fork
      begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_disabled_push();
        t_enable();
        t_burst();
        t_full();
        t_nak_flush();
        t_cmd_new();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule